// File: doc/BRIEF.md
# Time-Shared In-Place Radix-2 FFT Engine

This block computes a complex FFT or inverse FFT of length N = 2^LOG2N. It owns a single-port RAM of N complex words. The host fills the RAM through the host port while the engine is idle, pulses `start` with the wanted direction on `inverse`, waits for the one-cycle `done` pulse, and then reads the transformed words back through the same port. One radix-2 decimation-in-frequency butterfly does every operation. The RAM allows one access per clock, so each butterfly takes four cycles: read the top word, read the bottom word, write the top result, write the bottom result.

Twiddle factors come from one real table that holds N cosine samples, quantised to TW_W bits with 2^(TW_W-2) standing for 1.0. The table is read twice per butterfly. The real part is read at the exponent. The imaginary part is read a quarter period further on, and its sign is flipped for the inverse direction. Every stage halves its outputs, so a forward run yields the DFT divided by N and an inverse run yields the ordinary inverse DFT. Results sit in bit-reversed order.

Top module: `fft_inplace_engine`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: While `busy` is 0, a cycle with `host_we`=1 writes {`host_wre`,`host_wim`} to word `host_addr`. A cycle with `host_we`=0 reads word `host_addr`, and the word shows on `host_rre`/`host_rim` one cycle later. It stays there until the next read.
- R3: If `start` is 1 while `busy` is 0, a run begins at that clock edge. `busy` is then 1 for exactly 2·N·LOG2N cycles. `done` is 1 for exactly one cycle, the first cycle with `busy` back at 0, and is 0 at every other time.
- R4: A `start` pulse while `busy` is 1 is ignored. The run keeps its length and direction, and no second `done` follows.
- R5: Host writes while `busy` is 1 are ignored. The final RAM contents are the same as if no such write had been made.
- R6: Forward run, bit-exact. Stages s = 0..LOG2N-1 run in order, with h = N>>(s+1). For every address A with bit h clear, the pair a = word A and b = word A+h is replaced as follows. Word A becomes rnd((a+b)/2). Word A+h becomes rnd((a−b)·W/2^(TW_W−1)), computed separately on the real and imaginary parts. Here W = C(e) − j·S(e), e = (A mod h)·2^s, C(e) = round(cos(2πe/N)·2^(TW_W−2)) and S(e) = round(sin(2πe/N)·2^(TW_W−2)). rnd rounds half up, that is floor(x+0.5). Word k then holds DFT[bitrev(k)]/N, apart from rounding.
- R7: An inverse run uses the same schedule and the same rounding as R6, with the conjugate twiddle W = C(e) + j·S(e).
- R8: The direction is taken from `inverse` in the cycle that `start` is accepted. Changes on `inverse` during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| inverse | input | 1 | 1 selects the inverse transform, sampled with start |
| host_we | input | 1 | Host write strobe (idle only); 0 means read |
| host_addr | input | LOG2N | Host word address |
| host_wre | input | DATA_W | Host write data, real part (signed) |
| host_wim | input | DATA_W | Host write data, imaginary part (signed) |
| host_rre | output | DATA_W | Read data, real part (signed) |
| host_rim | output | DATA_W | Read data, imaginary part (signed) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run has finished |

## Verification
The bench builds the engine with LOG2N = 4, 26-bit data and 18-bit twiddles. That gives four stages of eight butterflies and a 128-cycle run. It reaches every twiddle exponent, including the quarter-period wrap of the imaginary lookup and both signs of the conjugate. A behavioural model predicts `busy` and `done` on every clock. It recomputes the whole transform from real-valued sine and cosine, so the rounding of each stage is checked bit for bit on impulse, constant and pseudo-random inputs in both directions, and also with start pulses, host writes and direction changes made during a run.

// File: rtl/fft_eng_pkg.sv
package fft_eng_pkg;
  parameter int DATA_W = 26;
  parameter int TW_W   = 18;

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } cplx_t;

  // arithmetic shift right by sh with round-half-up
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] x, input int sh);
    logic signed [63:0] half;
    half = 64'sd1 <<< (sh - 1);
    return (x + half) >>> sh;
  endfunction

  function automatic logic signed [63:0] sext(input logic signed [DATA_W-1:0] v);
    return {{(64-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  function automatic logic signed [63:0] sext_tw(input logic signed [TW_W-1:0] v);
    return {{(64-TW_W){v[TW_W-1]}}, v};
  endfunction
endpackage

// File: rtl/fft_ram.sv
module fft_ram
  import fft_eng_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  cplx_t         wdata,
  output cplx_t         q
);
  localparam int DEPTH = 1 << AW;

  cplx_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read port register only moves on read cycles
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (!we) q <= mem[addr];
  end
endmodule

// File: rtl/fft_agen.sv
module fft_agen #(
  parameter int LOG2N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             run,
  output logic [1:0]       ph,
  output logic [LOG2N-1:0] addr_a,
  output logic [LOG2N-1:0] addr_b,
  output logic [LOG2N-2:0] tw_exp,
  output logic             last
);
  localparam int EW = LOG2N - 1;
  localparam int SW = $clog2(LOG2N);

  logic [1:0]       ph_q;
  logic [EW-1:0]    j_q;
  logic [SW-1:0]    s_q;
  logic [LOG2N-1:0] jx, mask, low;
  int               pos;

  always_ff @(posedge clk) begin
    if (!rst_n || go) begin
      ph_q <= '0;
      j_q  <= '0;
      s_q  <= '0;
    end else if (run) begin
      ph_q <= ph_q + 2'd1;
      if (ph_q == 2'd3) begin
        j_q <= j_q + 1'b1;
        if (&j_q) s_q <= s_q + 1'b1;
      end
    end
  end

  // pair index j: insert a zero at bit position (LOG2N-1-stage)
  always_comb begin
    pos    = LOG2N - 1 - int'(s_q);
    jx     = {1'b0, j_q};
    mask   = (LOG2N'(1) << pos) - LOG2N'(1);
    low    = jx & mask;
    addr_a = ((jx & ~mask) << 1) | low;
    addr_b = addr_a | (LOG2N'(1) << pos);
    tw_exp = EW'(low << s_q);
  end

  assign ph   = ph_q;
  assign last = run && (&ph_q) && (&j_q) && (s_q == SW'(LOG2N - 1));

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$past(go) && (s_q != $past(s_q)) |-> ($past(ph_q) == 2'd3) && (&$past(j_q))) // R6
    else $error("stage advanced mid-stage");

  AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(addr_a ^ addr_b) == 1) && (addr_a < addr_b)) // R6
    else $error("butterfly pair malformed");
endmodule

// File: rtl/fft_twid.sv
module fft_twid
  import fft_eng_pkg::*;
#(
  parameter int LOG2N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LOG2N-2:0]       tw_exp,
  input  logic                   sel_im,
  input  logic                   inv,
  output logic signed [TW_W-1:0] tw_val
);
  localparam int    N     = 1 << LOG2N;
  localparam real   PI    = 3.14159265358979323846;
  localparam real   SCALE = 2.0 ** (TW_W - 2);
  localparam int    ONE   = 1 << (TW_W - 2);

  function automatic logic signed [TW_W-1:0] cos_q(input int k);
    real v;
    v = $cos(2.0 * PI * real'(k) / real'(N)) * SCALE;
    if (v >= 0.0) return TW_W'($rtoi(v + 0.5));
    else          return -TW_W'($rtoi(0.5 - v));
  endfunction

  logic signed [TW_W-1:0] tab [N];
  for (genvar k = 0; k < N; k++) begin : g_tab
    localparam logic signed [TW_W-1:0] CV = cos_q(k);
    assign tab[k] = CV;
  end

  logic [LOG2N-1:0]       idx;
  logic signed [TW_W-1:0] raw;

  // imaginary part: cos(theta + pi/2) = -sin(theta); negate for the conjugate
  always_comb begin
    idx    = sel_im ? ({1'b0, tw_exp} + LOG2N'(N / 4)) : {1'b0, tw_exp};
    raw    = tab[idx];
    tw_val = (sel_im && inv) ? -raw : raw;
  end

  AST_TW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_val <= TW_W'(ONE)) && (tw_val >= -TW_W'(ONE))) // R6
    else $error("twiddle out of unit range");
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
  import fft_eng_pkg::*;
(
  input  cplx_t                  a,
  input  cplx_t                  b,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output cplx_t                  y_top,
  output cplx_t                  y_bot
);
  logic signed [63:0] dr, di, wr, wi, pr, pi;

  // decimation in frequency: top = (a+b)/2, bottom = (a-b)*W/2
  always_comb begin
    wr = sext_tw(w_re);
    wi = sext_tw(w_im);
    dr = sext(a.re) - sext(b.re);
    di = sext(a.im) - sext(b.im);
    pr = dr * wr - di * wi;
    pi = dr * wi + di * wr;
    y_top.re = DATA_W'(rnd_shr(sext(a.re) + sext(b.re), 1));
    y_top.im = DATA_W'(rnd_shr(sext(a.im) + sext(b.im), 1));
    y_bot.re = DATA_W'(rnd_shr(pr, TW_W - 1));
    y_bot.im = DATA_W'(rnd_shr(pi, TW_W - 1));
  end
endmodule

// File: rtl/fft_inplace_engine.sv
module fft_inplace_engine
  import fft_eng_pkg::*;
#(
  parameter int LOG2N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     inverse,
  input  logic                     host_we,
  input  logic [LOG2N-1:0]         host_addr,
  input  logic signed [DATA_W-1:0] host_wre,
  input  logic signed [DATA_W-1:0] host_wim,
  output logic signed [DATA_W-1:0] host_rre,
  output logic signed [DATA_W-1:0] host_rim,
  output logic                     busy,
  output logic                     done
);
  logic busy_q, done_q, inv_q, go, run_last;
  logic [1:0]             ph;
  logic [LOG2N-1:0]       addr_a, addr_b, ram_addr;
  logic [LOG2N-2:0]       tw_exp;
  logic signed [TW_W-1:0] tw_val, tw_re, tw_im;
  logic                   ram_we;
  cplx_t                  ram_wdata, ram_q, a_reg, y_top, y_bot, yb_reg;

  assign go = start && !busy_q;

  fft_agen #(.LOG2N(LOG2N)) u_agen (
    .clk(clk), .rst_n(rst_n), .go(go), .run(busy_q), .ph(ph),
    .addr_a(addr_a), .addr_b(addr_b), .tw_exp(tw_exp), .last(run_last));

  fft_twid #(.LOG2N(LOG2N)) u_twid (
    .clk(clk), .rst_n(rst_n), .tw_exp(tw_exp), .sel_im(ph == 2'd1),
    .inv(inv_q), .tw_val(tw_val));

  fft_bfly u_bfly (
    .a(a_reg), .b(ram_q), .w_re(tw_re), .w_im(tw_im),
    .y_top(y_top), .y_bot(y_bot));

  fft_ram #(.AW(LOG2N)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q));

  // one RAM access per cycle: read top, read bottom, write top, write bottom
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = host_addr;
    ram_wdata = '{re: host_wre, im: host_wim};
    if (busy_q) begin
      unique case (ph)
        2'd0: ram_addr = addr_a;
        2'd1: ram_addr = addr_b;
        2'd2: begin ram_addr = addr_a; ram_we = 1'b1; ram_wdata = y_top;  end
        default: begin ram_addr = addr_b; ram_we = 1'b1; ram_wdata = yb_reg; end
      endcase
    end else begin
      ram_we = host_we;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      done_q <= run_last;
      if (go) begin
        busy_q <= 1'b1;
        inv_q  <= inverse;
      end else if (run_last) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tw_re  <= '0;
      tw_im  <= '0;
      a_reg  <= '0;
      yb_reg <= '0;
    end else if (busy_q) begin
      if (ph == 2'd0) tw_re <= tw_val;
      if (ph == 2'd1) begin
        tw_im <= tw_val;
        a_reg <= ram_q;
      end
      if (ph == 2'd2) yb_reg <= y_bot;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign host_rre = ram_q.re;
  assign host_rim = ram_q.im;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) // R3
    else $error("done longer than one cycle");

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q) && !busy_q) // R3
    else $error("done without finished run");

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !run_last |=> busy_q && $stable(inv_q)) // R4
    else $error("start disturbed a run");

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(inv_q)) // R8
    else $error("direction changed mid-run");

  AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ram_we && ph == 2'd2 |-> $past(busy_q) && !$past(ram_we)) // R5
    else $error("writeback not preceded by a read");
endmodule

// File: tb/fft_inplace_engine_test.sv
module fft_inplace_engine_test;
  import fft_eng_pkg::*;

  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int TOTAL = 2 * N * LOG2N;
  localparam real PI   = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, inverse = 1'b0, host_we = 1'b0;
  logic [LOG2N-1:0] host_addr = '0;
  logic signed [DATA_W-1:0] host_wre = '0, host_wim = '0;
  logic signed [DATA_W-1:0] host_rre, host_rim;
  logic busy, done;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  longint m_re [N];
  longint m_im [N];

  always #5 clk = ~clk;

  fft_inplace_engine #(.LOG2N(LOG2N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse),
    .host_we(host_we), .host_addr(host_addr), .host_wre(host_wre), .host_wim(host_wim),
    .host_rre(host_rre), .host_rim(host_rim), .busy(busy), .done(done));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint qround(input real v);
    return longint'($floor(v * (2.0 ** (TW_W - 2)) + 0.5));
  endfunction

  function automatic longint half_up(input longint x, input int k);
    return (x + (longint'(1) <<< (k - 1))) >>> k;
  endfunction

  // behavioural in-place transform with the rounding of R6/R7
  task automatic model_fft(input bit inv);
    for (int s = 0; s < LOG2N; s++) begin
      int h = N >> (s + 1);
      for (int a = 0; a < N; a++) begin
        if ((a & h) == 0) begin
          int b = a + h;
          int e = (a % h) << s;
          longint c  = qround($cos(2.0 * PI * e / N));
          longint sn = qround($sin(2.0 * PI * e / N));
          longint wi = inv ? sn : -sn;
          longint dr = m_re[a] - m_re[b];
          longint di = m_im[a] - m_im[b];
          m_re[a] = half_up(m_re[a] + m_re[b], 1);
          m_im[a] = half_up(m_im[a] + m_im[b], 1);
          m_re[b] = half_up(dr * c - di * wi, TW_W - 1);
          m_im[b] = half_up(dr * wi + di * c, TW_W - 1);
        end
      end
    end
  endtask

  task automatic host_write(input int addr, input longint re, input longint im);
    host_we = 1'b1; host_addr = LOG2N'(addr);
    host_wre = DATA_W'(re); host_wim = DATA_W'(im);
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load(input longint re [N], input longint im [N]);
    for (int k = 0; k < N; k++) begin
      host_write(k, re[k], im[k]);
      m_re[k] = re[k]; m_im[k] = im[k];
    end
  endtask

  task automatic readback(input string req);
    for (int k = 0; k < N; k++) begin
      host_addr = LOG2N'(k);
      @(posedge clk); @(negedge clk);
      check(req, longint'(host_rre), m_re[k]);
      check(req, longint'(host_rim), m_im[k]);
    end
  endtask

  // start a run; optionally disturb it mid-way; compare busy/done each clock
  task automatic run(input bit inv, input bit disturb);
    inverse = inv; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= TOTAL; c++) begin
      check("R3 busy during run", longint'(busy), 1);
      check("R3 no early done", longint'(done), 0);
      if (disturb && c == 3) inverse = ~inv;              // R8
      if (disturb && c == 5) begin
        start = 1'b1;                                     // R4
        host_we = 1'b1; host_addr = 3;                    // R5
        host_wre = 26'sd12345; host_wim = -26'sd777;
      end
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
    end
    check("R3 busy drops", longint'(busy), 0);
    check("R3 done pulse", longint'(done), 1);
    @(negedge clk);
    check("R3 done single", longint'(done), 0);
    check("R4 no second run", longint'(busy), 0);
    model_fft(inv);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint re [N];
    longint im [N];
    int lfsr = 32'h1ace;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", longint'(busy), 0);
    check("R1 done after reset", longint'(done), 0);

    // R2 load and read back untouched
    for (int k = 0; k < N; k++) begin re[k] = k * 1000 - 7000; im[k] = 300 - k * 77; end
    load(re, im);
    readback("R2 host readback");

    // R6 impulse, forward
    for (int k = 0; k < N; k++) begin re[k] = 0; im[k] = 0; end
    re[0] = 1 << 20; im[0] = -(1 << 18);
    load(re, im); run(1'b0, 1'b0); readback("R6 impulse forward");

    // R6 constant, forward
    for (int k = 0; k < N; k++) begin re[k] = 40001; im[k] = -12345; end
    load(re, im); run(1'b0, 1'b0); readback("R6 constant forward");

    // R6 pseudo-random, forward
    for (int k = 0; k < N; k++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      re[k] = (lfsr % (1 << 22)) - (1 << 21);
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      im[k] = (lfsr % (1 << 22)) - (1 << 21);
    end
    load(re, im); run(1'b0, 1'b0); readback("R6 random forward");

    // R7 inverse on the previous result left in RAM
    run(1'b1, 1'b0); readback("R7 inverse");

    // R4 R5 R8 disturbed forward run
    for (int k = 0; k < N; k++) begin re[k] = (k % 3) * 90000 - 50000; im[k] = k * k * 500; end
    load(re, im); run(1'b0, 1'b1); readback("R4 R5 R8 disturbed forward");

    // R7 R8 disturbed inverse run
    load(re, im); run(1'b1, 1'b1); readback("R7 R8 disturbed inverse");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule